// File: doc/BRIEF.md
# Three-Stage Wormhole Router

This block is a small N-by-N wormhole router for an on-chip network. Each input port takes flits over a valid/ready handshake into a local FIFO. Flits then pass through three pipeline stages. In route computation, a flit is read from the FIFO and a route is chosen for it. In switch allocation, a per-output round-robin arbiter grants the flit and consumes one downstream credit. In switch traversal, the flit is driven onto a registered output link. Head flits set the route of a packet. Body and tail flits follow the route of their packet's head. An output that has been granted to a multi-flit packet stays tied to that packet's input until the tail has been granted.

Both the control fields (valid, chosen output) and the flit data are registered at the end of route computation and again at the end of switch allocation. Consecutive flits of one packet can therefore overlap stages, and so can the head of the following packet. The router adds no cycles of its own. Stalls come only from two inputs contending for one output or from an output running out of credits. Each output starts with a credit count equal to the downstream buffer depth. The count drops by one for every flit granted and rises by one for every single-cycle pulse on that output's credit return.

Top module: `wh_router`

## Requirements
- R1: A flit is FW = PAYLOAD_W+2 bits wide. Bits [FW-1:FW-2] hold its type: 2'b00 single-flit packet, 2'b01 head, 2'b10 body, 2'b11 tail. A head or single flit is delivered to the output whose number is in payload bits [DW-1:0], with DW = log2(N). Every flit appears there bit-for-bit unchanged, and at most one flit appears per output per cycle.
- R2: When the pipeline is empty and credit is available, a flit accepted on an input at clock edge E appears on its output (out_valid high) after edge E+3.
- R3: Flits pushed on one input in consecutive cycles leave their output in consecutive cycles, with no idle cycle. This holds across the boundary between one packet's tail and the next packet's head, provided the downstream side returns a credit in each cycle it receives a flit.
- R4: Each output starts with CREDITS credits. It never delivers more flits than CREDITS plus the number of credit-return pulses received, and each later return pulse releases exactly one more waiting flit.
- R5: Once a head flit from one input is granted an output, no flit from any other input is delivered on that output until the tail of that packet has been delivered.
- R6: Each output arbitrates round-robin among the inputs waiting with a head or single flit. The priority pointer starts at input 0 after reset and moves to the input after the winner only when a head or single flit is granted.
- R7: Body and tail flits follow the output chosen by their packet's head, whatever their own payload bits [DW-1:0] hold.
- R8: During and right after reset, every out_valid bit is 0 and every in_ready bit is 1.
- R9: An input's in_ready goes low once its FIFO holds FIFO_DEPTH flits, and goes high again after a flit leaves that FIFO.
- R10: Flits from different inputs to different outputs cross the router in the same cycles, without affecting one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | Per-input flit valid |
| in_ready | output | N | Per-input FIFO can accept a flit |
| in_flit | input | N*FW | Input flits, input i in bits [i*FW +: FW] |
| out_valid | output | N | Per-output flit valid on the link |
| out_flit | output | N*FW | Output flits, output j in bits [j*FW +: FW] |
| credit_ret | input | N | One-cycle pulse per freed downstream buffer slot, per output |

## Verification
The bench builds the router with its defaults: four ports, 8-bit payload, four-deep input FIFOs and four credits per output. With only four credits, exhausting an output and filling the stalled input's FIFO takes just nine flits. Four inputs are enough to reach a three-way round-robin rotation, a locked output with a competing packet, and a full permutation in which all outputs are busy at once. The two-bit destination field lets a body flit's payload point at a different output than its head, which separates route-following from fresh lookup.

// File: rtl/wh_pkg.sv
`timescale 1ns/1ps
package wh_pkg;

    typedef enum logic [1:0] {
        FT_SINGLE = 2'b00,
        FT_HEAD   = 2'b01,
        FT_BODY   = 2'b10,
        FT_TAIL   = 2'b11
    } flit_type_e;

    // A flit that starts a packet carries the destination.
    function automatic logic starts_pkt(input logic [1:0] t);
        return (t == FT_HEAD) || (t == FT_SINGLE);
    endfunction

    // A flit that ends a packet releases the output.
    function automatic logic ends_pkt(input logic [1:0] t);
        return (t == FT_TAIL) || (t == FT_SINGLE);
    endfunction

endpackage

// File: rtl/wh_fifo.sv
`timescale 1ns/1ps
module wh_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CNTW-1:0] cnt;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (cnt == CNTW'(DEPTH));
    assign empty   = (cnt == '0);
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= step(wp);
            if (rd_en) rp <= step(rp);
            case ({wr_en, rd_en})
                2'b10:   cnt <= cnt + CNTW'(1);
                2'b01:   cnt <= cnt - CNTW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/wh_input_unit.sv
`timescale 1ns/1ps
module wh_input_unit
    import wh_pkg::*;
#(
    parameter int N         = 4,
    parameter int PAYLOAD_W = 8,
    parameter int DEPTH     = 4,
    localparam int FW       = PAYLOAD_W + 2,
    localparam int DW       = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [FW-1:0] in_flit,
    output logic          req_v,
    output logic [DW-1:0] req_dst,
    output logic          req_open,
    output logic          req_close,
    input  logic          granted,
    output logic          sa_v,
    output logic [DW-1:0] sa_dst,
    output logic [FW-1:0] sa_flit
);
    logic          q_full, q_empty, q_rd;
    logic [FW-1:0] q_head;
    logic [1:0]    q_type;
    logic [DW-1:0] route_q, route_new;

    // route computation slot (control + data)
    logic          rc_v;
    logic [DW-1:0] rc_dst;
    logic [FW-1:0] rc_flit;

    assign in_ready = !q_full;

    wh_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_valid && !q_full),
        .wr_data (in_flit),
        .rd_en   (q_rd),
        .rd_data (q_head),
        .full    (q_full),
        .empty   (q_empty)
    );

    assign q_type    = q_head[FW-1:FW-2];
    assign route_new = starts_pkt(q_type) ? q_head[DW-1:0] : route_q;
    // slot loads when empty or when its flit is leaving this cycle
    assign q_rd      = !q_empty && (!rc_v || granted);

    always_ff @(posedge clk) begin
        if (rst) begin
            rc_v    <= 1'b0;
            rc_dst  <= '0;
            rc_flit <= '0;
            route_q <= '0;
            sa_v    <= 1'b0;
            sa_dst  <= '0;
            sa_flit <= '0;
        end else begin
            if (q_rd) begin
                rc_v    <= 1'b1;
                rc_flit <= q_head;
                rc_dst  <= route_new;
                route_q <= route_new;
            end else if (granted) begin
                rc_v <= 1'b0;
            end
            sa_v <= granted;
            if (granted) begin
                sa_flit <= rc_flit;
                sa_dst  <= rc_dst;
            end
        end
    end

    assign req_v     = rc_v;
    assign req_dst   = rc_dst;
    assign req_open  = starts_pkt(rc_flit[FW-1:FW-2]);
    assign req_close = ends_pkt(rc_flit[FW-1:FW-2]);
endmodule

// File: rtl/wh_out_alloc.sv
`timescale 1ns/1ps
module wh_out_alloc #(
    parameter int N        = 4,
    parameter int CREDITS  = 4,
    localparam int IW      = $clog2(N),
    localparam int CW      = $clog2(CREDITS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  open_v,
    input  logic [N-1:0]  close_v,
    input  logic          credit_ret,
    output logic [N-1:0]  gnt,
    output logic          lock_o,
    output logic [IW-1:0] owner_o,
    output logic [CW-1:0] credit_o
);
    logic          lock_q;
    logic [IW-1:0] owner_q, ptr_q, win;
    logic [CW-1:0] credit_q;
    logic [N-1:0]  elig;
    logic          found, fire;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            elig[i] = req[i] && (lock_q ? (owner_q == IW'(i)) : open_v[i]);
        end
    end

    always_comb begin
        int idx;
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr_q) + k) % N;
            if (!found && elig[idx]) begin
                found = 1'b1;
                win   = IW'(idx);
            end
        end
        fire = found && (credit_q != '0);
        gnt  = '0;
        if (fire) gnt[win] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q   <= 1'b0;
            owner_q  <= '0;
            ptr_q    <= '0;
            credit_q <= CW'(CREDITS);
        end else begin
            case ({fire, credit_ret})
                2'b10:   credit_q <= credit_q - CW'(1);
                2'b01:   credit_q <= credit_q + CW'(1);
                default: credit_q <= credit_q;
            endcase
            if (fire) begin
                if (close_v[win]) begin
                    lock_q <= 1'b0;
                end else if (open_v[win]) begin
                    lock_q  <= 1'b1;
                    owner_q <= win;
                end
                if (open_v[win]) begin
                    ptr_q <= (win == IW'(N - 1)) ? '0 : win + IW'(1);
                end
            end
        end
    end

    assign lock_o   = lock_q;
    assign owner_o  = owner_q;
    assign credit_o = credit_q;
endmodule

// File: rtl/wh_router.sv
`timescale 1ns/1ps
module wh_router #(
    parameter int N          = 4,
    parameter int PAYLOAD_W  = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int CREDITS    = FIFO_DEPTH,
    localparam int FW        = PAYLOAD_W + 2,
    localparam int DW        = $clog2(N),
    localparam int CW        = $clog2(CREDITS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    in_valid,
    output logic [N-1:0]    in_ready,
    input  logic [N*FW-1:0] in_flit,
    output logic [N-1:0]    out_valid,
    output logic [N*FW-1:0] out_flit,
    input  logic [N-1:0]    credit_ret
);
    logic [N-1:0]          req_v, req_open, req_close, granted, sa_v;
    logic [N-1:0][DW-1:0]  req_dst, sa_dst;
    logic [N-1:0][FW-1:0]  sa_flit, st_mux, out_q;
    logic [N-1:0][N-1:0]   req_mat, gnt_mat, sa_hit;
    logic [N-1:0]          lock_v;
    logic [N-1:0][DW-1:0]  owner_v;
    logic [N-1:0][CW-1:0]  credit_v;

    for (genvar i = 0; i < N; i++) begin : g_in
        wh_input_unit #(.N(N), .PAYLOAD_W(PAYLOAD_W), .DEPTH(FIFO_DEPTH)) u_in (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid[i]),
            .in_ready  (in_ready[i]),
            .in_flit   (in_flit[i*FW +: FW]),
            .req_v     (req_v[i]),
            .req_dst   (req_dst[i]),
            .req_open  (req_open[i]),
            .req_close (req_close[i]),
            .granted   (granted[i]),
            .sa_v      (sa_v[i]),
            .sa_dst    (sa_dst[i]),
            .sa_flit   (sa_flit[i])
        );
    end

    for (genvar j = 0; j < N; j++) begin : g_mat
        for (genvar i = 0; i < N; i++) begin : g_cell
            assign req_mat[j][i] = req_v[i] && (req_dst[i] == DW'(j));
            assign sa_hit[j][i]  = sa_v[i]  && (sa_dst[i]  == DW'(j));
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        wh_out_alloc #(.N(N), .CREDITS(CREDITS)) u_alloc (
            .clk        (clk),
            .rst        (rst),
            .req        (req_mat[j]),
            .open_v     (req_open),
            .close_v    (req_close),
            .credit_ret (credit_ret[j]),
            .gnt        (gnt_mat[j]),
            .lock_o     (lock_v[j]),
            .owner_o    (owner_v[j]),
            .credit_o   (credit_v[j])
        );
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            granted[i] = 1'b0;
            for (int j = 0; j < N; j++) granted[i] = granted[i] | gnt_mat[j][i];
        end
    end

    // switch traversal: crossbar into registered link
    always_comb begin
        for (int j = 0; j < N; j++) begin
            st_mux[j] = '0;
            for (int i = 0; i < N; i++) begin
                if (sa_hit[j][i]) st_mux[j] = st_mux[j] | sa_flit[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= '0;
            out_q     <= '0;
        end else begin
            for (int j = 0; j < N; j++) begin
                out_valid[j] <= |sa_hit[j];
                out_q[j]     <= st_mux[j];
            end
        end
    end

    assign out_flit = out_q;
endmodule

// File: rtl/wh_router_chk.sv
`timescale 1ns/1ps
module wh_router_chk #(
    parameter int N       = 4,
    parameter int CREDITS = 4,
    parameter int DW      = 2,
    parameter int CW      = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N-1:0]         out_valid,
    input logic [N-1:0]         credit_ret,
    input logic [N-1:0][N-1:0]  sa_hit,
    input logic [N-1:0]         lock_v,
    input logic [N-1:0][DW-1:0] owner,
    input logic [N-1:0][CW-1:0] credit
);
    int outstanding [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < N; j++) outstanding[j] <= 0;
        end else begin
            for (int j = 0; j < N; j++)
                outstanding[j] <= outstanding[j] + int'(out_valid[j]) - int'(credit_ret[j]);
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_chk
        // R1: one flit per output per cycle through the crossbar
        assert_xbar_single_R1: assert property (@(posedge clk) disable iff (rst)
            $onehot0(sa_hit[j]));

        // R2: a switched flit reaches the link on the next edge
        assert_st_follow_R2: assert property (@(posedge clk) disable iff (rst)
            (|sa_hit[j]) |=> out_valid[j]);

        assert_st_idle_R2: assert property (@(posedge clk) disable iff (rst)
            !(|sa_hit[j]) |=> !out_valid[j]);

        // R4: credits held + flits in flight + unreturned flits stay constant
        assert_credit_conserve_R4: assert property (@(posedge clk) disable iff (rst)
            int'(credit[j]) + int'(|sa_hit[j]) + int'(out_valid[j]) + outstanding[j] == CREDITS);

        // R5: owner of a locked output does not change while locked
        assert_lock_owner_R5: assert property (@(posedge clk) disable iff (rst)
            (lock_v[j] && $past(lock_v[j])) |-> $stable(owner[j]));
    end
endmodule

bind wh_router wh_router_chk #(.N(N), .CREDITS(CREDITS), .DW(DW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_valid  (out_valid),
    .credit_ret (credit_ret),
    .sa_hit     (sa_hit),
    .lock_v     (lock_v),
    .owner      (owner_v),
    .credit     (credit_v)
);

// File: tb/sim_wh_router.sv
`timescale 1ns/1ps
module sim_wh_router;
    localparam int N  = 4;
    localparam int PW = 8;
    localparam int FW = PW + 2;
    localparam int DEPTH = 4;

    localparam int T_S = 0, T_H = 1, T_B = 2, T_T = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    in_valid = '0;
    logic [N-1:0]    in_ready;
    logic [N*FW-1:0] in_flit = '0;
    logic [N-1:0]    out_valid;
    logic [N*FW-1:0] out_flit;
    logic [N-1:0]    credit_ret = '0;

    int nchk = 0, nfail = 0, cyc = 0, last_acc = 0;
    int log_flit [N][64];
    int log_cyc  [N][64];
    int log_n    [N];
    logic [N-1:0] auto_cr = '1;
    int man_cr [N];

    wh_router #(.N(N), .PAYLOAD_W(PW), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_flit(in_flit), .out_valid(out_valid), .out_flit(out_flit),
        .credit_ret(credit_ret)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // downstream model: record deliveries, return credits
    always @(negedge clk) begin
        for (int j = 0; j < N; j++) begin
            if (rst) begin
                log_n[j] = 0;
                credit_ret[j] = 1'b0;
            end else begin
                if (out_valid[j] && log_n[j] < 64) begin
                    log_flit[j][log_n[j]] = int'(out_flit[j*FW +: FW]);
                    log_cyc[j][log_n[j]]  = cyc;
                    log_n[j] = log_n[j] + 1;
                end
                credit_ret[j] = (auto_cr[j] && out_valid[j]) || (man_cr[j] > 0);
                if (man_cr[j] > 0) man_cr[j] = man_cr[j] - 1;
            end
        end
    end

    function automatic int mk(int t, int src, int low);
        return (t << PW) | (src << 4) | low;
    endfunction

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(int p, int f);
        while (!in_ready[p]) @(negedge clk);
        in_valid[p] = 1'b1;
        in_flit[p*FW +: FW] = FW'(f);
        @(negedge clk);
        last_acc = cyc;
        in_valid[p] = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = '0;
        auto_cr = '1;
        for (int j = 0; j < N; j++) man_cr[j] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 out_valid in reset", int'(out_valid), 0);
        chk("R8 in_ready in reset", int'(in_ready), (1 << N) - 1);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R8 out_valid after reset", int'(out_valid), 0);
        chk("R8 in_ready after reset", int'(in_ready), (1 << N) - 1);
    endtask

    task automatic t_latency();
        int acc;
        do_reset();
        push(0, mk(T_S, 0, 2));
        acc = last_acc;
        idle(8);
        chk("R1 delivered on out2", log_n[2], 1);
        chk("R1 no stray output", log_n[0] + log_n[1] + log_n[3], 0);
        chk("R1 flit unchanged", log_flit[2][0], mk(T_S, 0, 2));
        chk("R2 latency three edges", log_cyc[2][0], acc + 3);
    endtask

    task automatic t_stream();
        int exp [6];
        do_reset();
        exp[0] = mk(T_H, 1, 3); exp[1] = mk(T_B, 1, 4'h4); exp[2] = mk(T_T, 1, 4'h1);
        exp[3] = mk(T_S, 1, 3); exp[4] = mk(T_H, 1, 3);    exp[5] = mk(T_T, 1, 4'h2);
        for (int k = 0; k < 6; k++) push(1, exp[k]);
        idle(10);
        chk("R3 count on out3", log_n[3], 6);
        chk("R7 body/tail not rerouted", log_n[0] + log_n[1] + log_n[2], 0);
        for (int k = 0; k < 6; k++) chk("R7 order and data", log_flit[3][k], exp[k]);
        for (int k = 1; k < 6; k++) chk("R3 no idle cycle", log_cyc[3][k], log_cyc[3][0] + k);
    endtask

    task automatic t_credit();
        int exp [9];
        do_reset();
        auto_cr[0] = 1'b0;
        for (int k = 0; k < 9; k++)
            exp[k] = mk((k == 0) ? T_H : (k == 8) ? T_T : T_B, 2, (k == 0) ? 0 : 3);
        for (int k = 0; k < 9; k++) push(2, exp[k]);
        idle(10);
        chk("R4 stops at credit limit", log_n[0], 4);
        chk("R9 in_ready low when FIFO full", int'(in_ready[2]), 0);
        man_cr[0] = 1;
        idle(8);
        chk("R4 one return releases one flit", log_n[0], 5);
        chk("R9 in_ready back after dequeue", int'(in_ready[2]), 1);
        man_cr[0] = 4;
        idle(15);
        chk("R4 all flits after returns", log_n[0], 9);
        for (int k = 0; k < 9; k++) chk("R4 order kept", log_flit[0][k], exp[k]);
    endtask

    task automatic t_lock();
        int exp [6];
        do_reset();
        exp[0] = mk(T_H, 0, 2); exp[1] = mk(T_B, 0, 5); exp[2] = mk(T_T, 0, 6);
        exp[3] = mk(T_H, 1, 2); exp[4] = mk(T_B, 1, 5); exp[5] = mk(T_T, 1, 6);
        fork
            begin for (int k = 0; k < 3; k++) push(0, exp[k]); end
            begin for (int k = 3; k < 6; k++) push(1, exp[k]); end
        join
        idle(12);
        chk("R5 count on out2", log_n[2], 6);
        for (int k = 0; k < 6; k++) chk("R5 packets not interleaved", log_flit[2][k], exp[k]);
    endtask

    task automatic t_rr();
        int src_exp [6];
        do_reset();
        src_exp[0] = 0; src_exp[1] = 1; src_exp[2] = 3;
        src_exp[3] = 0; src_exp[4] = 1; src_exp[5] = 3;
        for (int r = 0; r < 2; r++) begin
            fork
                push(0, mk(T_S, 0, 1));
                push(1, mk(T_S, 1, 1));
                push(3, mk(T_S, 3, 1));
            join
        end
        idle(14);
        chk("R6 count on out1", log_n[1], 6);
        for (int k = 0; k < 6; k++)
            chk("R6 round-robin order", (log_flit[1][k] >> 4) & 15, src_exp[k]);
    endtask

    task automatic t_parallel();
        do_reset();
        fork
            push(0, mk(T_S, 0, 1));
            push(1, mk(T_S, 1, 0));
            push(2, mk(T_S, 2, 3));
            push(3, mk(T_S, 3, 2));
        join
        idle(8);
        for (int j = 0; j < N; j++) chk("R10 one flit per output", log_n[j], 1);
        chk("R10 out0 from in1", log_flit[0][0], mk(T_S, 1, 0));
        chk("R10 out3 from in2", log_flit[3][0], mk(T_S, 2, 3));
        for (int j = 1; j < N; j++) chk("R10 same cycle", log_cyc[j][0], log_cyc[0][0]);
    endtask

    initial begin
        for (int j = 0; j < N; j++) man_cr[j] = 0;
        t_reset();
        t_latency();
        t_stream();
        t_credit();
        t_lock();
        t_rr();
        t_parallel();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule